// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic unit of a small 8-bit processor core. It takes two operands, an operation code and a bit index. In the same cycle it returns the result, a write-enable for that result, and the flag set that the operation would produce. The flag register is held inside the block. It loads the new flag set on a rising clock edge only when the update strobe is high, and each operation works from the flags it currently holds.

The flag rules are chosen so that multi-byte arithmetic can be chained. Increment and decrement leave the carry untouched. The with-carry subtract and compare forms can clear the zero flag but never set it. So a compare followed by several compares-with-carry ends with zero set only when the whole wide difference is zero. The sign flag is always the XOR of negative and overflow, so it gives the correct sign of a signed comparison.

Flag vector bit order (flags_o, flags_next_o): bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H, bit 6 T.

Top module: `alu8_flags`

## Requirements
- R1: rst_ni low clears flags_o to 0. On a rising clk_i edge with upd_i high, flags_o takes the value of flags_next_o. With upd_i low, flags_o holds.
- R2: ADD (op 0) and ADC (op 1, adds C as well) give the 8-bit sum. C is the carry out of bit 7, H is the carry out of bit 3, and V is set on signed overflow.
- R3: SUB (op 2), SBC (op 3, also subtracts C), CP (op 4) and CPC (op 5, also subtracts C) give A minus B. C is set on an unsigned borrow and H on a borrow from bit 4. V is set on signed overflow. NEG (op 12) gives 0 minus A, with C set when the result is nonzero, H set when A[3:0] is nonzero, and V set when the result is 0x80.
- R4: SBC and CPC set Z to the old Z when the result is zero, and clear Z when the result is nonzero. SUB, CP and NEG set Z exactly when the result is zero.
- R5: CP and CPC update the flags like the matching subtract, but hold wr_en_o low.
- R6: INC (op 6) and DEC (op 7) leave C and H unchanged. INC sets V only when A is 0x7F, and DEC sets V only when A is 0x80.
- R7: Every operation that updates flags (codes 0 to 12 and 14 to 16) sets N to result bit 7 and Z to "result is zero" (except as in R4). All of them set S to N XOR V.
- R8: AND (op 8), OR (op 9) and XOR (op 10) clear V and keep C and H. COM (op 11) gives the one's complement, sets C, clears V and keeps H.
- R9: LSR (op 14) shifts in 0, ROR (op 15) shifts in the old C, and ASR (op 16) keeps bit 7. In all three, C takes the old bit 0, V becomes N XOR C and H is kept.
- R10: SWAP (op 13) exchanges the two nibbles and leaves every flag unchanged.
- R11: BST (op 17) copies A[bit_sel_i] into T, shows A on result_o, holds wr_en_o low and leaves the other flags unchanged. BLD (op 18) returns A with bit bit_sel_i replaced by T and leaves every flag unchanged.
- R12: Codes 19 to 31 give result 0, hold wr_en_o low and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the flag register |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination) |
| b_i | input | 8 | Second operand |
| bit_sel_i | input | 3 | Bit index for BST and BLD |
| upd_i | input | 1 | Load flags_next_o into the flag register at the next edge |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Result should be written back |
| flags_next_o | output | 7 | Flag set produced by the current operation |
| flags_o | output | 7 | Registered flag set |

## Verification
result_o, wr_en_o and flags_next_o are combinational, so they are due in the same cycle as the operands. The bench drives on the falling edge and compares one time unit later, before the next rising edge. flags_o is due one rising edge after a vector with upd_i high. The monitor checks it against the reference flag state that held before that vector was applied, which is what the register shows at the same sampling point. Multi-byte compare chains and runs with upd_i low test the feedback path across several cycles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int OP_W   = 5;
  localparam int SEL_W  = $clog2(DATA_W);

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CP   = 5'd4,
    OP_CPC  = 5'd5,
    OP_INC  = 5'd6,
    OP_DEC  = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_COM  = 5'd11,
    OP_NEG  = 5'd12,
    OP_SWAP = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROR  = 5'd15,
    OP_ASR  = 5'd16,
    OP_BST  = 5'd17,
    OP_BLD  = 5'd18
  } op_e;

  // bit 0 = c ... bit 6 = t
  typedef struct packed {
    logic t;
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  flags_t            cur_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            nxt_o,
  output logic              hit_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] x, y;
  logic              cin, sub, keep_c, chain_z;
  logic [DATA_W:0]   full;
  logic [HALF_W:0]   low;

  // all forms reduce to x + y + cin; subtract inverts carries
  always_comb begin
    x       = a_i;
    y       = b_i;
    cin     = 1'b0;
    sub     = 1'b0;
    keep_c  = 1'b0;
    chain_z = 1'b0;
    hit_o   = 1'b1;
    case (op_i)
      OP_ADD: ;
      OP_ADC: cin = cur_i.c;
      OP_SUB, OP_CP: begin
        y   = ~b_i;
        cin = 1'b1;
        sub = 1'b1;
      end
      OP_SBC, OP_CPC: begin
        y       = ~b_i;
        cin     = ~cur_i.c;
        sub     = 1'b1;
        chain_z = 1'b1;
      end
      OP_INC: begin
        y      = '0;
        cin    = 1'b1;
        keep_c = 1'b1;
      end
      OP_DEC: begin
        y      = '1;
        keep_c = 1'b1;
      end
      OP_NEG: begin
        x   = '0;
        y   = ~a_i;
        cin = 1'b1;
        sub = 1'b1;
      end
      default: hit_o = 1'b0;
    endcase
  end

  assign full  = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  assign low   = {1'b0, x[HALF_W-1:0]} + {1'b0, y[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
  assign res_o = full[DATA_W-1:0];

  always_comb begin
    nxt_o   = cur_i;
    nxt_o.n = res_o[MSB];
    nxt_o.v = (x[MSB] == y[MSB]) && (res_o[MSB] != x[MSB]);
    nxt_o.s = nxt_o.n ^ nxt_o.v;
    nxt_o.z = (res_o == '0) && (!chain_z || cur_i.z);
    if (!keep_c) begin
      nxt_o.c = full[DATA_W] ^ sub;
      nxt_o.h = low[HALF_W] ^ sub;
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SEL_W-1:0]  bit_sel_i,
  input  flags_t            cur_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            nxt_o,
  output logic              hit_o
);
  localparam int MSB = DATA_W - 1;

  logic set_nzs, shift_v;

  always_comb begin
    res_o   = a_i;
    nxt_o   = cur_i;
    hit_o   = 1'b1;
    set_nzs = 1'b1;
    shift_v = 1'b0;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_COM: begin
        res_o   = ~a_i;
        nxt_o.c = 1'b1;
      end
      OP_SWAP: begin
        res_o   = {a_i[HALF_W-1:0], a_i[DATA_W-1:HALF_W]};
        set_nzs = 1'b0;
      end
      OP_LSR, OP_ROR, OP_ASR: begin
        res_o[MSB-1:0] = a_i[MSB:1];
        res_o[MSB]     = (op_i == OP_ROR) ? cur_i.c :
                         (op_i == OP_ASR) ? a_i[MSB] : 1'b0;
        nxt_o.c        = a_i[0];
        shift_v        = 1'b1;
      end
      OP_BST: begin
        nxt_o.t = a_i[bit_sel_i];
        set_nzs = 1'b0;
      end
      OP_BLD: begin
        res_o[bit_sel_i] = cur_i.t;
        set_nzs          = 1'b0;
      end
      default: begin
        hit_o   = 1'b0;
        set_nzs = 1'b0;
      end
    endcase
    if (set_nzs) begin
      nxt_o.n = res_o[MSB];
      nxt_o.z = (res_o == '0);
      nxt_o.v = shift_v ? (res_o[MSB] ^ nxt_o.c) : 1'b0;
      nxt_o.s = nxt_o.n ^ nxt_o.v;
    end
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (upd_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SEL_W-1:0]  bit_sel_i,
  input  logic              upd_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_next_o,
  output logic [FLAG_W-1:0] flags_o
);
  op_e               op;
  flags_t            cur, nxt, nxt_a, nxt_l;
  logic [DATA_W-1:0] res_a, res_l;
  logic              hit_a, hit_l;

  assign op = op_e'(op_i);

  alu8_arith u_arith (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .cur_i (cur),
    .res_o (res_a),
    .nxt_o (nxt_a),
    .hit_o (hit_a)
  );

  alu8_logic u_logic (
    .op_i      (op),
    .a_i       (a_i),
    .b_i       (b_i),
    .bit_sel_i (bit_sel_i),
    .cur_i     (cur),
    .res_o     (res_l),
    .nxt_o     (nxt_l),
    .hit_o     (hit_l)
  );

  always_comb begin
    if (hit_a) begin
      result_o = res_a;
      nxt      = nxt_a;
    end else if (hit_l) begin
      result_o = res_l;
      nxt      = nxt_l;
    end else begin
      result_o = '0;
      nxt      = cur;
    end
  end

  assign wr_en_o = (hit_a || hit_l) && !(op inside {OP_CP, OP_CPC, OP_BST});

  alu8_flagreg u_flagreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd_i),
    .d_i    (nxt),
    .q_o    (cur)
  );

  assign flags_next_o = nxt;
  assign flags_o      = cur;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic              upd_i,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [FLAG_W-1:0] flags_next_o,
  input logic [FLAG_W-1:0] flags_o
);
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;

  logic nz_op, chain_op;
  assign nz_op    = (op_i <= 5'd12) || (op_i >= 5'd14 && op_i <= 5'd16);
  assign chain_op = (op_i == 5'd3) || (op_i == 5'd5);

  // R1
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_o));

  // R1
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flags_o == $past(flags_next_o));

  // R7
  sign_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FS] == (flags_o[FN] ^ flags_o[FV]));

  // R7
  neg_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nz_op |-> flags_next_o[FN] == result_o[DATA_W-1]);

  // R4
  chain_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_op && !flags_o[FZ]) |-> !flags_next_o[FZ]);

  // R5
  cmp_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd4 || op_i == 5'd5) |-> !wr_en_o);

  // R6
  incdec_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd6 || op_i == 5'd7) |-> flags_next_o[FC] == flags_o[FC]);

  // R10
  swap_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd13 || op_i == 5'd18) |-> flags_next_o == flags_o);

  // R12
  unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 5'd18) |-> (!wr_en_o && result_o == '0 && flags_next_o == flags_o));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_i         (op_i),
  .upd_i        (upd_i),
  .result_o     (result_o),
  .wr_en_o      (wr_en_o),
  .flags_next_o (flags_next_o),
  .flags_o      (flags_o)
);

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5, FT = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [2:0] bit_sel_i = '0;
  logic       upd_i = 1'b0;
  logic [7:0] result_o;
  logic       wr_en_o;
  logic [6:0] flags_next_o, flags_o;

  typedef struct {
    logic [7:0] res;
    logic       we;
    logic [6:0] nxt;
    logic [6:0] cur;
    string      tag;
  } item_t;

  item_t      sb_q[$];
  event       applied;
  int         n_vec = 0, n_bad = 0;
  logic [6:0] model_f = '0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alu8_flags u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .bit_sel_i(bit_sel_i), .upd_i(upd_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .flags_next_o(flags_next_o), .flags_o(flags_o)
  );

  function automatic int sx(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  function automatic void model(input logic [4:0] op, input logic [7:0] a, b,
                                input logic [2:0] bs, input logic [6:0] f,
                                output logic [7:0] r, output logic we,
                                output logic [6:0] nf);
    int  t, ht, sv, cin;
    bit  nzs;
    nf = f; we = 1'b1; r = '0; nzs = 1'b1;
    case (op)
      5'd0, 5'd1: begin
        cin = (op == 5'd1) ? int'(f[FC]) : 0;
        t = int'(a) + int'(b) + cin;
        ht = int'(a[3:0]) + int'(b[3:0]) + cin;
        sv = sx(a) + sx(b) + cin;
        r = 8'(t); nf[FC] = t > 255; nf[FH] = ht > 15;
        nf[FV] = sv > 127 || sv < -128;
      end
      5'd2, 5'd3, 5'd4, 5'd5: begin
        cin = (op == 5'd3 || op == 5'd5) ? int'(f[FC]) : 0;
        t = int'(a) - int'(b) - cin;
        ht = int'(a[3:0]) - int'(b[3:0]) - cin;
        sv = sx(a) - sx(b) - cin;
        r = 8'(t); nf[FC] = t < 0; nf[FH] = ht < 0;
        nf[FV] = sv > 127 || sv < -128;
        we = (op < 5'd4);
      end
      5'd6, 5'd7: begin
        sv = (op == 5'd6) ? sx(a) + 1 : sx(a) - 1;
        r = (op == 5'd6) ? a + 8'd1 : a - 8'd1;
        nf[FV] = sv > 127 || sv < -128;
      end
      5'd8:  begin r = a & b; nf[FV] = 1'b0; end
      5'd9:  begin r = a | b; nf[FV] = 1'b0; end
      5'd10: begin r = a ^ b; nf[FV] = 1'b0; end
      5'd11: begin r = ~a; nf[FC] = 1'b1; nf[FV] = 1'b0; end
      5'd12: begin
        r = 8'd0 - a; nf[FC] = a != 0; nf[FH] = a[3:0] != 0;
        nf[FV] = -sx(a) > 127;
      end
      5'd13: begin r = {a[3:0], a[7:4]}; nzs = 1'b0; end
      5'd14, 5'd15, 5'd16: begin
        r = a >> 1;
        if (op == 5'd15) r[7] = f[FC];
        if (op == 5'd16) r[7] = a[7];
        nf[FC] = a[0];
        nf[FV] = r[7] ^ a[0];
      end
      5'd17: begin r = a; we = 1'b0; nf[FT] = a[bs]; nzs = 1'b0; end
      5'd18: begin r = a; r[bs] = f[FT]; nzs = 1'b0; end
      default: begin we = 1'b0; nzs = 1'b0; end
    endcase
    if (nzs) begin
      nf[FN] = r[7];
      nf[FZ] = (r == 0) && (!(op == 5'd3 || op == 5'd5) || f[FZ]);
      nf[FS] = nf[FN] ^ nf[FV];
    end
  endfunction

  task automatic apply(input logic [4:0] op, input logic [7:0] a, b,
                       input logic [2:0] bs, input logic upd, input string tag);
    item_t it;
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; bit_sel_i = bs; upd_i = upd;
    model(op, a, b, bs, model_f, it.res, it.we, it.nxt);
    it.cur = model_f;
    it.tag = tag;
    sb_q.push_back(it);
    -> applied;
    if (upd) model_f = it.nxt;
  endtask

  task automatic check_now(input logic [31:0] act, exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: combinational outputs and the flag register, before the next rising edge
  initial forever begin
    item_t it;
    @(applied);
    #1;
    it = sb_q.pop_front();
    n_vec++;
    if (result_o !== it.res || wr_en_o !== it.we ||
        flags_next_o !== it.nxt || flags_o !== it.cur) begin
      n_bad++;
      $display("FAIL %s act res=%0h we=%0b nxt=%0h flg=%0h exp res=%0h we=%0b nxt=%0h flg=%0h",
               it.tag, result_o, wr_en_o, flags_next_o, flags_o,
               it.res, it.we, it.nxt, it.cur);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    check_now(32'(flags_o), 32'h0, "R1 reset");
    rst_ni = 1'b1;

    // R2 add: half carry, carry, overflow
    apply(5'd0, 8'h0F, 8'h01, 0, 1, "R2 add half carry");
    apply(5'd0, 8'hFF, 8'h01, 0, 1, "R2 add carry zero");
    apply(5'd1, 8'h10, 8'h20, 0, 1, "R2 adc carry in");
    apply(5'd0, 8'h7F, 8'h01, 0, 1, "R2 add overflow");
    // R3 subtract and negate
    apply(5'd2, 8'h10, 8'h01, 0, 1, "R3 sub half borrow");
    apply(5'd2, 8'h00, 8'h01, 0, 1, "R3 sub borrow");
    apply(5'd3, 8'h80, 8'h00, 0, 1, "R3 sbc overflow");
    apply(5'd12, 8'h80, 8'h00, 0, 1, "R3 neg 80");
    apply(5'd12, 8'h00, 8'h00, 0, 1, "R3 neg zero");
    // R4 / R5 16-bit compare chains
    apply(5'd4, 8'h34, 8'h34, 0, 1, "R5 cp low equal");
    apply(5'd5, 8'h12, 8'h12, 0, 1, "R4 cpc high equal keeps Z");
    apply(5'd4, 8'h35, 8'h34, 0, 1, "R5 cp low differ");
    apply(5'd5, 8'h12, 8'h12, 0, 1, "R4 cpc zero cannot set Z");
    apply(5'd4, 8'h00, 8'h01, 0, 1, "R4 cp borrow");
    apply(5'd5, 8'h13, 8'h12, 0, 1, "R4 cpc with borrow zero");
    apply(5'd3, 8'h05, 8'h02, 0, 1, "R4 sbc nonzero clears Z");
    // R6 carry survives inc/dec
    apply(5'd11, 8'h00, 8'h00, 0, 1, "R8 com sets C");
    apply(5'd6, 8'h7F, 8'h00, 0, 1, "R6 inc 7f");
    apply(5'd7, 8'h80, 8'h00, 0, 1, "R6 dec 80");
    apply(5'd7, 8'h01, 8'h00, 0, 1, "R6 dec to zero");
    // R8 logic
    apply(5'd8, 8'hF0, 8'h0F, 0, 1, "R8 and zero");
    apply(5'd9, 8'h80, 8'h01, 0, 1, "R8 or neg");
    apply(5'd10, 8'hAA, 8'hFF, 0, 1, "R8 xor");
    // R9 shifts
    apply(5'd14, 8'h81, 8'h00, 0, 1, "R9 lsr");
    apply(5'd15, 8'h02, 8'h00, 0, 1, "R9 ror carry in");
    apply(5'd16, 8'h81, 8'h00, 0, 1, "R9 asr");
    // R10 swap
    apply(5'd13, 8'h3C, 8'h00, 0, 1, "R10 swap");
    // R11 bit transfer
    apply(5'd17, 8'h20, 8'h00, 5, 1, "R11 bst one");
    apply(5'd18, 8'h00, 8'h00, 3, 1, "R11 bld");
    apply(5'd17, 8'hDF, 8'h00, 5, 1, "R11 bst zero");
    apply(5'd18, 8'hFF, 8'h00, 7, 1, "R11 bld clear");
    // R12 unassigned codes
    apply(5'd19, 8'hFF, 8'hFF, 0, 1, "R12 code 19");
    apply(5'd31, 8'h12, 8'h34, 0, 1, "R12 code 31");
    // R1 hold with strobe low
    apply(5'd0, 8'hFF, 8'hFF, 0, 0, "R1 no update");
    apply(5'd2, 8'h00, 8'h01, 0, 0, "R1 still held");
    apply(5'd8, 8'h00, 8'h00, 0, 1, "R1 update again");

    for (int i = 0; i < 600; i++)
      apply(5'($urandom_range(0, 21)), 8'($urandom), 8'($urandom),
            3'($urandom), 1'($urandom_range(0, 3) != 0), "R7 random");

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    upd_i = 1'b0;
    #2 rst_ni = 1'b0;
    #1 check_now(32'(flags_o), 32'h0, "R1 async reset");
    model_f = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(5'd2, 8'h00, 8'h00, 0, 1, "R7 zero after reset");
    apply(5'd0, 8'h00, 8'h00, 0, 0, "R1 reset then load");

    @(negedge clk_i);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule